// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block computes and holds the 12-bit program counter of a small 8-bit microcontroller. On each cycle where an instruction completes, the control logic gives it an instruction class, the opcode byte, the second instruction byte, a branch-condition result and, for table jumps, the byte read from program memory. The block then loads the counter from one of several sources:

- a wrapping step of one or two bytes
- a long target built from the bank flag, three opcode bits and the second byte
- a short target that replaces only the low byte
- a page-relative target taken from the fetched byte

The block also holds a one-bit memory-bank flag. Bank-select instructions write this flag, and it supplies PC bit 11 only when a long jump or call executes. The unit does not evaluate conditions, including the decrement-and-test of a register loop. It also does not read program memory. For the table jump it supplies the read address, which is the current page joined to the accumulator, and it takes the returned byte on `tbl_byte`.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x000 and the bank flag is 0. A long jump issued first after reset therefore produces a target with bit 11 clear.
- R2: Class code 0 (one-byte step) loads `pc` with bits 10:0 incremented by one, wrapping from 0x7FF to 0x000 within those 11 bits, and leaves bit 11 unchanged.
- R3: Class code 1 (two-byte step) adds two to bits 10:0 with the same 11-bit wrap, and leaves bit 11 unchanged.
- R4: Class code 2 (long jump or call) loads `pc` as follows:
  - bit 11 from the bank flag
  - bits 10:8 from `opcode[7:5]`
  - bits 7:0 from `op_byte2`
- R5: Class code 5 (bank select) writes `opcode[4]` into the bank flag and steps `pc` by one. The new flag value does not change `pc` bit 11 until a later long jump. No other class changes the flag.
- R6: Class code 3 (short conditional branch) with `take_br` high loads bits 7:0 from `op_byte2`. Bits 11:8 are the upper bits of the address of the second instruction byte, which is the current PC stepped by one. So a branch whose first byte sits at the last address of a page lands in the following page.
- R7: Class code 3 with `take_br` low steps `pc` by two, with the same wrap rule as R3.
- R8: Class code 4 (table jump) keeps `pc` bits 11:8 and loads bits 7:0 from `tbl_byte`. Output `tbl_addr` is always `{pc[11:8], acc}`.
- R9: While `op_done` is low, `pc` holds its value. In every cycle, `pc_next` shows the value that `pc` takes at the next clock edge when `op_done` is high.
- R10: The unused class codes 6 and 7 act as a one-byte step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done | input | 1 | An instruction completes this cycle |
| op_class | input | 3 | Instruction class code (see requirements) |
| opcode | input | 8 | First instruction byte |
| op_byte2 | input | 8 | Second instruction byte |
| take_br | input | 1 | Branch condition result |
| acc | input | 8 | Accumulator value |
| tbl_byte | input | 8 | Byte read from program memory at `tbl_addr` |
| pc | output | 12 | Current program counter |
| pc_next | output | 12 | Value loaded at the next completing instruction |
| tbl_addr | output | 12 | Table-read address, current page plus accumulator |

## Verification
The bench builds the block with its default parameters: a 12-bit counter and 8-bit pages. With these values, the 11-bit wrap at 0x7FF and 0xFFF is reached in a few jumps. Page crossings for short branches sit at every 0x?FF address. Directed steps place the PC at these edges in both banks. A long random run of mixed classes then compares `pc` and `pc_next` against a behavioural model every cycle.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [2:0] {
    CLS_STEP1 = 3'd0,
    CLS_STEP2 = 3'd1,
    CLS_LONG  = 3'd2,
    CLS_SHORT = 3'd3,
    CLS_TABLE = 3'd4,
    CLS_BANK  = 3'd5
  } op_class_e;

endpackage

// File: rtl/pc_wrap_inc.sv
module pc_wrap_inc #(
  parameter int PC_W = 12
) (
  input  logic [PC_W-1:0] pc_in,
  input  logic [1:0]      step,
  output logic [PC_W-1:0] pc_out
);

  localparam int LOW_W = PC_W - 1;

  function automatic logic [PC_W-1:0] wrap_add(input logic [PC_W-1:0] p,
                                               input logic [1:0] s);
    logic [LOW_W-1:0] low;
    low = p[LOW_W-1:0] + LOW_W'(s);
    return {p[PC_W-1], low};
  endfunction

  assign pc_out = wrap_add(pc_in, step);

endmodule

// File: rtl/pc_bank_flag.sv
module pc_bank_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic k_in,
  output logic bank_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= 1'b0;
    else if (set_en) bank_q <= k_in;
  end

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(bank_q));

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bank_q == $past(k_in));

endmodule

// File: rtl/pc_target_sel.sv
module pc_target_sel
  import pc_next_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int PG_W = 8
) (
  input  logic [2:0]       op_class,
  input  logic [OPC_W-1:0] opcode,
  input  logic [PG_W-1:0]  op_byte2,
  input  logic             take_br,
  input  logic [PG_W-1:0]  tbl_byte,
  input  logic [PC_W-1:0]  pc_q,
  input  logic             bank_q,
  input  logic [PC_W-1:0]  pc_inc1,
  input  logic [PC_W-1:0]  pc_inc2,
  output logic [PC_W-1:0]  pc_nx,
  output logic             sel_long,
  output logic             sel_short_taken,
  output logic             sel_table
);

  localparam int HI_W = PC_W - 1 - PG_W;

  function automatic logic [PC_W-1:0] long_target(input logic b,
                                                  input logic [OPC_W-1:0] op,
                                                  input logic [PG_W-1:0] lo);
    return {b, op[OPC_W-1 -: HI_W], lo};
  endfunction

  function automatic logic [PC_W-1:0] page_target(input logic [PC_W-1:0] base,
                                                  input logic [PG_W-1:0] lo);
    return {base[PC_W-1:PG_W], lo};
  endfunction

  logic [PC_W-1:0] long_tgt, short_tgt, table_tgt;

  assign long_tgt  = long_target(bank_q, opcode, op_byte2);
  assign short_tgt = page_target(pc_inc1, op_byte2);
  assign table_tgt = page_target(pc_q, tbl_byte);

  assign sel_long        = (op_class == CLS_LONG);
  assign sel_short_taken = (op_class == CLS_SHORT) && take_br;
  assign sel_table       = (op_class == CLS_TABLE);

  always_comb begin
    unique case (op_class)
      CLS_STEP2: pc_nx = pc_inc2;
      CLS_LONG:  pc_nx = long_tgt;
      CLS_SHORT: pc_nx = take_br ? short_tgt : pc_inc2;
      CLS_TABLE: pc_nx = table_tgt;
      default:   pc_nx = pc_inc1;
    endcase
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int PG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_done,
  input  logic [2:0]       op_class,
  input  logic [OPC_W-1:0] opcode,
  input  logic [PG_W-1:0]  op_byte2,
  input  logic             take_br,
  input  logic [PG_W-1:0]  acc,
  input  logic [PG_W-1:0]  tbl_byte,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  pc_next,
  output logic [PC_W-1:0]  tbl_addr
);

  logic [PC_W-1:0] pc_q, pc_inc1, pc_inc2, pc_nx;
  logic            bank_q, bank_wr;
  logic            sel_long, sel_short_taken, sel_table;

  assign bank_wr = op_done && (op_class == CLS_BANK);

  pc_wrap_inc #(.PC_W(PC_W)) u_inc1 (.pc_in(pc_q), .step(2'd1), .pc_out(pc_inc1));
  pc_wrap_inc #(.PC_W(PC_W)) u_inc2 (.pc_in(pc_q), .step(2'd2), .pc_out(pc_inc2));

  pc_bank_flag u_bank (
    .clk(clk), .rst_n(rst_n), .set_en(bank_wr), .k_in(opcode[4]), .bank_q(bank_q)
  );

  pc_target_sel #(.PC_W(PC_W), .PG_W(PG_W)) u_sel (
    .op_class(op_class), .opcode(opcode), .op_byte2(op_byte2), .take_br(take_br),
    .tbl_byte(tbl_byte), .pc_q(pc_q), .bank_q(bank_q), .pc_inc1(pc_inc1),
    .pc_inc2(pc_inc2), .pc_nx(pc_nx), .sel_long(sel_long),
    .sel_short_taken(sel_short_taken), .sel_table(sel_table)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (op_done) pc_q <= pc_nx;
  end

  assign pc       = pc_q;
  assign pc_next  = pc_nx;
  assign tbl_addr = {pc_q[PC_W-1:PG_W], acc};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (pc_q == '0 && bank_q == 1'b0);
    end
  end

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> $stable(pc_q));

  // R2
  step_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && op_class == CLS_STEP1 |=> pc_q[PC_W-1] == $past(pc_q[PC_W-1]));

  // R4
  long_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && sel_long |=> pc_q[PC_W-1] == $past(bank_q)
                            && pc_q[PG_W-1:0] == $past(op_byte2));

  // R7
  short_nt_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && op_class == CLS_SHORT && !take_br
      |=> pc_q[PC_W-1] == $past(pc_q[PC_W-1]));

  // R8
  table_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && sel_table |=> pc_q[PC_W-1:PG_W] == $past(pc_q[PC_W-1:PG_W])
                             && pc_q[PG_W-1:0] == $past(tbl_byte));

  // R6
  short_taken_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && sel_short_taken |=> pc_q[PG_W-1:0] == $past(op_byte2));

endmodule

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_done = 1'b0;
  logic [2:0]  op_class = '0;
  logic [7:0]  opcode = '0, op_byte2 = '0, acc = '0, tbl_byte = '0;
  logic        take_br = 1'b0;
  logic [11:0] pc, pc_next, tbl_addr;

  int errors = 0;
  int checks = 0;
  int m_pc = 0;
  int m_bank = 0;

  always #5 clk = ~clk;

  pc_next_unit i_pc_next_unit (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_class(op_class),
    .opcode(opcode), .op_byte2(op_byte2), .take_br(take_br), .acc(acc),
    .tbl_byte(tbl_byte), .pc(pc), .pc_next(pc_next), .tbl_addr(tbl_addr)
  );

  function automatic int step_by(int p, int n);
    return (p & 'h800) | ((p + n) & 'h7FF);
  endfunction

  function automatic int model_next(int p, int b, int cls, int op, int b2, int t, int tb);
    case (cls)
      1: return step_by(p, 2);
      2: return b * 2048 + ((op >> 5) & 7) * 256 + b2;
      3: return t ? ((step_by(p, 1) & 'hF00) | b2) : step_by(p, 2);
      4: return (p & 'hF00) | tb;
      default: return step_by(p, 1);
    endcase
  endfunction

  function automatic string tag_of(int cls, int t);
    case (cls)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return t ? "R6" : "R7";
      4: return "R8";
      5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  // called just after a falling edge
  task automatic do_op(bit v, int cls, int op, int b2, bit t, int tb, int a);
    int exp;
    op_done = v; op_class = 3'(cls); opcode = 8'(op); op_byte2 = 8'(b2);
    take_br = t; tbl_byte = 8'(tb); acc = 8'(a);
    exp = model_next(m_pc, m_bank, cls, op, b2, t, tb);
    #1;
    check({tag_of(cls, t), "/R9 pc_next"}, int'(pc_next), exp);
    check("R8 tbl_addr", int'(tbl_addr), (m_pc & 'hF00) | a);
    @(posedge clk);
    if (v) begin
      if (cls == 5) m_bank = (op >> 4) & 1;
      m_pc = exp;
    end
    @(negedge clk);
    check(v ? tag_of(cls, t) : "R9 hold", int'(pc), m_pc);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset pc", int'(pc), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first long jump after reset uses bank 0
    do_op(1, 2, 'hE4, 'h34, 0, 0, 0);
    check("R1 bank0 after reset", int'(pc), 'h734);
    // R5: select bank 1, step keeps bit 11
    do_op(1, 5, 'hF5, 0, 0, 0, 0);
    check("R5 bit11 unchanged", int'(pc), 'h735);
    do_op(1, 0, 0, 0, 0, 0, 0);
    // R4: long jump now sets bit 11
    do_op(1, 2, 'hE4, 'h34, 0, 0, 0);
    check("R4 bank1 target", int'(pc), 'hF34);
    // R3: wrap at 0xFFE
    do_op(1, 2, 'hE4, 'hFE, 0, 0, 0);
    do_op(1, 1, 0, 0, 0, 0, 0);
    check("R3 wrap keeps bit11", int'(pc), 'h800);
    // R5: back to bank 0, R2 wrap at 0x7FF
    do_op(1, 5, 'hE5, 0, 0, 0, 0);
    do_op(1, 2, 'hE4, 'hFF, 0, 0, 0);
    do_op(1, 0, 0, 0, 0, 0, 0);
    check("R2 wrap 7FF", int'(pc), 'h000);
    // R6: taken short branch at page end lands in next page
    do_op(1, 2, 'h24, 'hFF, 0, 0, 0);
    do_op(1, 3, 'hF6, 'h40, 1, 0, 0);
    check("R6 page crossing", int'(pc), 'h240);
    // R7: not taken at page end
    do_op(1, 2, 'h44, 'hFF, 0, 0, 0);
    do_op(1, 3, 'hE6, 'h40, 0, 0, 0);
    check("R7 not taken", int'(pc), 'h301);
    // R8: table jump keeps page
    do_op(1, 2, 'hA4, 'h10, 0, 0, 0);
    do_op(1, 4, 'hB3, 0, 0, 'h9A, 'h5C);
    check("R8 table", int'(pc), 'h59A);
    // R9: hold with a long jump presented
    do_op(0, 2, 'hE4, 'h00, 0, 0, 0);
    check("R9 hold", int'(pc), 'h59A);
    // R10: unused classes step by one
    do_op(1, 6, 0, 0, 0, 0, 0);
    do_op(1, 7, 0, 0, 0, 0, 0);
    check("R10 unused classes", int'(pc), 'h59C);
    // mixed run
    for (int i = 0; i < 2000; i++) begin
      do_op(($urandom % 8) != 0, int'($urandom % 8), int'($urandom % 256),
            int'($urandom % 256), 1'($urandom % 2), int'($urandom % 256),
            int'($urandom % 256));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule